// File: doc/BRIEF.md
# Accumulator and Temporary Register Bank

This block keeps the working registers of a small accumulator machine: the accumulator A and two scratch registers U and V, each one data word wide. Each cycle one command arrives as an operation code with a source and a destination register code. The command can load a register from the data bus, copy one register into another, exchange two registers, or put a register's value on the bus. Every register change takes effect on a single clock edge.

The block also produces the ALU's two inputs. The accumulator leaves as `acc_out`. The second input is picked by a 2-bit operand field: the memory byte currently addressed by the program counter, U, V, or a constant zero. All outputs are registered. The ALU and the memory addressing are outside the block.

Register codes used in `cmd_src` and `cmd_dst`: 0 = A, 1 = U, 2 = V, 3 = no register. Operation codes in `cmd_op`: 0 = idle, 1 = load, 2 = store, 3 = move, 4 = swap. Codes 5 to 7 are unused.

Top module: `acc_tmp_regbank`

## Requirements
- R1: A synchronous active-high `rst` clears A, U, V, `acc_out`, `opnd_out` and `bus_out` to zero and clears `bus_drive` at the clock edge where it is sampled high.
- R2: A load (op 1) writes `bus_in` into the register named by `cmd_dst` (0 = A, 1 = U, 2 = V) at the edge. With destination code 3 no register changes.
- R3: A move (op 3) copies the register named by `cmd_src` into the one named by `cmd_dst` at the edge and leaves the source unchanged. It changes nothing if either code is 3 or if both codes are equal.
- R4: A swap (op 4) exchanges the registers named by `cmd_src` and `cmd_dst` on the same edge, for any of the pairs A/U, A/V and U/V. It changes nothing if either code is 3 or if both codes are equal.
- R5: A store (op 2) with a source code of 0, 1 or 2 raises `bus_drive` in the next cycle, with `bus_out` equal to that register's value in the command cycle. No more than one register is ever selected to drive.
- R6: In the cycle after any command that is not a store with a valid source, including a store with source code 3, `bus_drive` is 0 and `bus_out` is zero.
- R7: After each edge, `opnd_out` holds the value picked by the `opnd_sel` sampled at that edge: 0 = `mem_byte`, 1 = U, 2 = V, 3 = zero. U and V are taken as they stand after that edge's update.
- R8: After each edge, `acc_out` equals A as it stands after that edge's update.
- R9: Op 0 and the unused codes 5, 6 and 7 leave A, U and V unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 3 | Operation code |
| cmd_src | input | 2 | Source register code |
| cmd_dst | input | 2 | Destination register code |
| bus_in | input | W | Data bus value for loads |
| mem_byte | input | W | Memory byte at the program counter |
| opnd_sel | input | 2 | Second-operand select |
| acc_out | output | W | Accumulator value |
| opnd_out | output | W | Selected second ALU operand |
| bus_out | output | W | Value driven on stores, zero otherwise |
| bus_drive | output | 1 | High while the block drives the bus |

## Verification
Several rules are checked by properties on every cycle: both halves of a swap land on one edge, a valid store puts the source's earlier value on the bus, at most one register is selected to drive, the bus output is zero while idle, idle and unused codes hold all registers, the zero operand code gives zero, and reset clears the outputs. The bench's scenarios show the rest. A reference model follows random and directed command streams and checks that loads and moves reach the right register, and that invalid or same-register commands do nothing. It also checks that the operand output shows U and V as they stand after the update in the same cycle, and that the accumulator output follows every kind of write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int NREG = 3;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_MOVE  = 3'd3,
    OP_SWAP  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RID_A    = 2'd0,
    RID_U    = 2'd1,
    RID_V    = 2'd2,
    RID_NONE = 2'd3
  } rid_e;

  // write source per register: from the bus, or from one of the registers
  typedef enum logic [1:0] {
    WS_BUS = 2'd0,
    WS_A   = 2'd1,
    WS_U   = 2'd2,
    WS_V   = 2'd3
  } wsrc_e;

  typedef enum logic [1:0] {
    OPS_MEM  = 2'd0,
    OPS_U    = 2'd1,
    OPS_V    = 2'd2,
    OPS_ZERO = 2'd3
  } opsel_e;

endpackage

// File: rtl/rb_cmd_decode.sv
module rb_cmd_decode
  import regbank_pkg::*;
(
  input  logic [2:0]            cmd_op,
  input  logic [1:0]            cmd_src,
  input  logic [1:0]            cmd_dst,
  output logic [NREG-1:0]       wr_en,
  output logic [NREG-1:0][1:0]  wr_sel,
  output logic [NREG-1:0]       drv_en
);

  logic src_ok, dst_ok, pair_ok;
  logic [1:0] src_ws, dst_ws;

  assign src_ok  = (cmd_src != RID_NONE);
  assign dst_ok  = (cmd_dst != RID_NONE);
  assign pair_ok = src_ok && dst_ok && (cmd_src != cmd_dst);
  assign src_ws  = cmd_src + 2'd1;
  assign dst_ws  = cmd_dst + 2'd1;

  always_comb begin
    wr_en  = '0;
    wr_sel = '0;
    drv_en = '0;
    for (int i = 0; i < NREG; i++) begin
      case (cmd_op)
        OP_LOAD: begin
          if (dst_ok && cmd_dst == i[1:0]) begin
            wr_en[i]  = 1'b1;
            wr_sel[i] = WS_BUS;
          end
        end
        OP_STORE: begin
          if (src_ok && cmd_src == i[1:0]) drv_en[i] = 1'b1;
        end
        OP_MOVE: begin
          if (pair_ok && cmd_dst == i[1:0]) begin
            wr_en[i]  = 1'b1;
            wr_sel[i] = src_ws;
          end
        end
        OP_SWAP: begin
          if (pair_ok && cmd_dst == i[1:0]) begin
            wr_en[i]  = 1'b1;
            wr_sel[i] = src_ws;
          end
          if (pair_ok && cmd_src == i[1:0]) begin
            wr_en[i]  = 1'b1;
            wr_sel[i] = dst_ws;
          end
        end
        default: ;
      endcase
    end
  end

  // R5: never more than one register selected to drive the bus
  always_comb begin
    assert_single_driver_R5: assert ($onehot0(drv_en) || $isunknown(cmd_op));
  end

endmodule

// File: rtl/rb_reg_file.sv
module rb_reg_file
  import regbank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          bus_in,
  input  logic [NREG-1:0]       wr_en,
  input  logic [NREG-1:0][1:0]  wr_sel,
  output logic [NREG-1:0][W-1:0] reg_q,
  output logic [NREG-1:0][W-1:0] reg_nxt
);

  // every register reads old values of all registers, so a swap needs no temp
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] pick;

    always_comb begin
      case (wr_sel[g])
        WS_BUS:  pick = bus_in;
        WS_A:    pick = reg_q[0];
        WS_U:    pick = reg_q[1];
        default: pick = reg_q[2];
      endcase
      reg_nxt[g] = wr_en[g] ? pick : reg_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) reg_q[g] <= '0;
      else     reg_q[g] <= reg_nxt[g];
    end
  end

endmodule

// File: rtl/rb_opnd_sel.sv
module rb_opnd_sel
  import regbank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   opnd_sel,
  input  logic [W-1:0] mem_byte,
  input  logic [W-1:0] u_nxt,
  input  logic [W-1:0] v_nxt,
  output logic [W-1:0] opnd_q
);

  logic [W-1:0] opnd_d;

  always_comb begin
    case (opnd_sel)
      OPS_MEM: opnd_d = mem_byte;
      OPS_U:   opnd_d = u_nxt;
      OPS_V:   opnd_d = v_nxt;
      default: opnd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) opnd_q <= '0;
    else     opnd_q <= opnd_d;
  end

  // R7: reserved select code yields a zero operand
  assert_zero_operand_R7: assert property (@(posedge clk) disable iff (rst)
    (opnd_sel == OPS_ZERO) |=> (opnd_q == '0));

endmodule

// File: rtl/rb_bus_drv.sv
module rb_bus_drv
  import regbank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREG-1:0]        drv_en,
  input  logic [NREG-1:0][W-1:0] reg_q,
  output logic [W-1:0]           bus_out,
  output logic                   bus_drive
);

  logic [W-1:0] drv_val;

  always_comb begin
    drv_val = '0;
    for (int i = 0; i < NREG; i++)
      if (drv_en[i]) drv_val = drv_val | reg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out   <= '0;
      bus_drive <= 1'b0;
    end else begin
      bus_out   <= drv_val;
      bus_drive <= |drv_en;
    end
  end

  // R6: idle bus output carries zero
  assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_drive |-> (bus_out == '0));

endmodule

// File: rtl/acc_tmp_regbank.sv
module acc_tmp_regbank
  import regbank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   cmd_op,
  input  logic [1:0]   cmd_src,
  input  logic [1:0]   cmd_dst,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] mem_byte,
  input  logic [1:0]   opnd_sel,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] opnd_out,
  output logic [W-1:0] bus_out,
  output logic         bus_drive
);

  logic [NREG-1:0]        wr_en;
  logic [NREG-1:0][1:0]   wr_sel;
  logic [NREG-1:0]        drv_en;
  logic [NREG-1:0][W-1:0] reg_q;
  logic [NREG-1:0][W-1:0] reg_nxt;

  rb_cmd_decode i_dec (
    .cmd_op (cmd_op),
    .cmd_src(cmd_src),
    .cmd_dst(cmd_dst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .drv_en (drv_en)
  );

  rb_reg_file #(.W(W)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .bus_in (bus_in),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .reg_q  (reg_q),
    .reg_nxt(reg_nxt)
  );

  rb_opnd_sel #(.W(W)) i_opnd (
    .clk     (clk),
    .rst     (rst),
    .opnd_sel(opnd_sel),
    .mem_byte(mem_byte),
    .u_nxt   (reg_nxt[1]),
    .v_nxt   (reg_nxt[2]),
    .opnd_q  (opnd_out)
  );

  rb_bus_drv #(.W(W)) i_bus (
    .clk      (clk),
    .rst      (rst),
    .drv_en   (drv_en),
    .reg_q    (reg_q),
    .bus_out  (bus_out),
    .bus_drive(bus_drive)
  );

  assign acc_out = reg_q[0];

  function automatic logic [W-1:0] rd(input logic [NREG-1:0][W-1:0] qq,
                                      input logic [1:0] id);
    case (id)
      RID_A:   return qq[0];
      RID_U:   return qq[1];
      RID_V:   return qq[2];
      default: return '0;
    endcase
  endfunction

  logic pair_ok, is_idle;
  assign pair_ok = (cmd_src != RID_NONE) && (cmd_dst != RID_NONE) && (cmd_src != cmd_dst);
  assign is_idle = (cmd_op == OP_IDLE) || (cmd_op > OP_SWAP);

  // R1: reset clears the visible outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && opnd_out == '0 && bus_out == '0 && !bus_drive));

  // R4: both registers of a swap exchange on the same edge
  assert_swap_exchange_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_SWAP && pair_ok) |=>
      (rd(reg_q, $past(cmd_dst)) == $past(rd(reg_q, cmd_src))) &&
      (rd(reg_q, $past(cmd_src)) == $past(rd(reg_q, cmd_dst))));

  // R5: a valid store drives the source's value from the command cycle
  assert_store_value_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_STORE && cmd_src != RID_NONE) |=>
      (bus_drive && bus_out == $past(rd(reg_q, cmd_src))));

  // R9: idle and unused codes hold every register
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    is_idle |=> $stable(reg_q));

endmodule

// File: tb/test_acc_tmp_regbank.sv
module test_acc_tmp_regbank;

  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   cmd_op = '0;
  logic [1:0]   cmd_src = '0;
  logic [1:0]   cmd_dst = '0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] mem_byte = '0;
  logic [1:0]   opnd_sel = '0;
  logic [W-1:0] acc_out, opnd_out, bus_out;
  logic         bus_drive;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] m [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_tmp_regbank #(.W(W)) i_acc_tmp_regbank (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .bus_in(bus_in), .mem_byte(mem_byte), .opnd_sel(opnd_sel),
    .acc_out(acc_out), .opnd_out(opnd_out), .bus_out(bus_out), .bus_drive(bus_drive)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one command through one clock edge, checked against the model
  task automatic step(input logic r, input logic [2:0] op, input logic [1:0] s,
                      input logic [1:0] d, input logic [W-1:0] bi,
                      input logic [W-1:0] mb, input logic [1:0] sel, input string tag);
    logic [W-1:0] n [3];
    logic [W-1:0] ebo, eop;
    logic ebd;
    logic pair;
    n = m; ebd = 1'b0; ebo = '0;
    pair = (s != 2'd3) && (d != 2'd3) && (s != d);
    rst = r; cmd_op = op; cmd_src = s; cmd_dst = d; bus_in = bi; mem_byte = mb; opnd_sel = sel;
    if (r) begin
      n[0] = '0; n[1] = '0; n[2] = '0;
    end else begin
      case (op)
        3'd1: if (d != 2'd3) n[d] = bi;
        3'd2: if (s != 2'd3) begin ebd = 1'b1; ebo = m[s]; end
        3'd3: if (pair) n[d] = m[s];
        3'd4: if (pair) begin n[d] = m[s]; n[s] = m[d]; end
        default: ;
      endcase
    end
    case (sel)
      2'd0: eop = mb;
      2'd1: eop = n[1];
      2'd2: eop = n[2];
      default: eop = '0;
    endcase
    if (r) eop = '0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "acc_out (R8)", acc_out, n[0]);
    chk(tag, "opnd_out (R7)", opnd_out, eop);
    chk(tag, "bus_drive", {{(W-1){1'b0}}, bus_drive}, {{(W-1){1'b0}}, ebd});
    chk(tag, "bus_out", bus_out, ebo);
    m = n;
  endtask

  // read U and V through the operand output without changing anything
  task automatic peek(input string tag);
    step(1'b0, 3'd0, 2'd0, 2'd0, '0, 8'h5A, 2'd1, tag);
    step(1'b0, 3'd0, 2'd0, 2'd0, '0, 8'h5A, 2'd2, tag);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    m[0] = '0; m[1] = '0; m[2] = '0;
    @(negedge clk);
    step(1'b1, 3'd1, 2'd0, 2'd0, 8'hFF, 8'hFF, 2'd0, "R1 reset");
    step(1'b1, 3'd2, 2'd1, 2'd1, 8'hFF, 8'hEE, 2'd1, "R1 reset");
    // R2 loads into each register
    step(1'b0, 3'd1, 2'd0, 2'd0, 8'h11, 8'h00, 2'd0, "R2 load A");
    step(1'b0, 3'd1, 2'd0, 2'd1, 8'h22, 8'h00, 2'd1, "R2 load U");
    step(1'b0, 3'd1, 2'd0, 2'd2, 8'h33, 8'h77, 2'd2, "R2 load V");
    step(1'b0, 3'd1, 2'd0, 2'd3, 8'h99, 8'h77, 2'd0, "R2 load none");
    peek("R2 no-dest check");
    // R4 swaps of every pair
    step(1'b0, 3'd4, 2'd0, 2'd1, 8'h00, 8'h00, 2'd1, "R4 swap A/U");
    step(1'b0, 3'd4, 2'd2, 2'd0, 8'h00, 8'h00, 2'd2, "R4 swap V/A");
    step(1'b0, 3'd4, 2'd1, 2'd2, 8'h00, 8'h00, 2'd1, "R4 swap U/V");
    step(1'b0, 3'd4, 2'd1, 2'd1, 8'h00, 8'h00, 2'd2, "R4 swap same");
    step(1'b0, 3'd4, 2'd3, 2'd0, 8'h00, 8'h00, 2'd1, "R4 swap none");
    // R3 moves
    step(1'b0, 3'd3, 2'd0, 2'd2, 8'h00, 8'h00, 2'd2, "R3 move A->V");
    step(1'b0, 3'd1, 2'd0, 2'd1, 8'hC4, 8'h00, 2'd1, "R2 load U");
    step(1'b0, 3'd3, 2'd1, 2'd0, 8'h00, 8'h00, 2'd1, "R3 move U->A");
    step(1'b0, 3'd3, 2'd3, 2'd1, 8'h00, 8'h00, 2'd1, "R3 move none");
    step(1'b0, 3'd3, 2'd2, 2'd2, 8'h00, 8'h00, 2'd2, "R3 move same");
    // R5/R6 stores
    step(1'b0, 3'd2, 2'd0, 2'd0, 8'h00, 8'h00, 2'd0, "R5 store A");
    step(1'b0, 3'd2, 2'd2, 2'd0, 8'h00, 8'h00, 2'd0, "R5 store V");
    step(1'b0, 3'd2, 2'd3, 2'd0, 8'h00, 8'h00, 2'd0, "R6 store none");
    step(1'b0, 3'd1, 2'd0, 2'd0, 8'hAB, 8'h00, 2'd3, "R6 after load, R7 zero");
    // R9 unused codes
    step(1'b0, 3'd5, 2'd0, 2'd1, 8'hEE, 8'h3C, 2'd0, "R9 op5");
    step(1'b0, 3'd6, 2'd1, 2'd2, 8'hEE, 8'h3C, 2'd1, "R9 op6");
    step(1'b0, 3'd7, 2'd2, 2'd0, 8'hEE, 8'h3C, 2'd2, "R9 op7");
    step(1'b0, 3'd0, 2'd2, 2'd0, 8'hEE, 8'h3C, 2'd3, "R9 idle");
    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 99) == 0), op, 2'($urandom), 2'($urandom),
           8'($urandom), 8'($urandom), 2'($urandom),
           (op == 3'd1) ? "R2 rand" : (op == 3'd2) ? "R5 rand" :
           (op == 3'd3) ? "R3 rand" : (op == 3'd4) ? "R4 rand" : "R9 rand");
    end
    // mid-run reset
    step(1'b1, 3'd1, 2'd0, 2'd0, 8'h5F, 8'h10, 2'd0, "R1 mid reset");
    peek("R1 mid reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule